// File: doc/BRIEF.md
# Cancellation Path Sequencer with Offset Calibration

This block controls a power-gated distortion-cancellation path that sits beside a main receive path. A coarse request input, such as a flag saying that transmit power is high, tells it when blocking may occur. When the request rises, the block powers up the reference front end and waits a fixed settling time. It then measures the DC offset of the reference baseband by averaging a quiet window of 2^N complex samples. From then on it subtracts that offset from every reference sample it forwards.

With the corrected reference running, a first-order leaky power detector on I^2+Q^2 watches for distortion energy. The adaptive canceller is enabled only after the detected power rises above an enable threshold. It is disabled again when the canceller's own summed output power estimate falls below a separate, lower threshold, which gives hysteresis. While the block is detecting but not cancelling, it recalibrates the offset after a programmable number of samples. When the request drops, the block returns to its idle state at the next clock edge, drops every enable and forgets the stored offset.

The offset subtraction is added on top of the slow high-pass filtering already present in the baseband paths and does not replace it. Its purpose is to remove the DC term before adaptation starts, so that the canceller does not stall while that filter settles.

Top module: `xcan_path_seq`

## Requirements
- R1: During and after reset with the request low, `state_o` is 0, and `fe_en_o`, `cxl_en_o` and `ref_valid_o` are 0. The state codes are: idle 0, front-end warm-up 1, calibration 2, detection 3, cancelling 4, recalibration 5.
- R2: A high request in idle moves the state to 1 at the next clock edge, and `fe_en_o` rises at that edge. State 1 lasts exactly WARM_CYC clock cycles and is followed by state 2.
- R3: Calibration takes exactly 2^N samples that have `smp_valid_i` high and then moves to state 3. Cycles with `smp_valid_i` low are not counted.
- R4: The stored offset is the per-channel sum of the window shifted right arithmetically by N, which rounds toward minus infinity. It is stored when the window ends. While the state is not 0, every valid sample produces `ref_valid_o`=1 one cycle later, with `ref_i_o`/`ref_q_o` (W+1 bits, signed) equal to the sample minus the stored offset.
- R5: The detector power is cleared outside state 3. In state 3, each valid corrected sample updates it to p - (p>>k) + ((I^2+Q^2)>>k), where k is `det_shift_i`.
- R6: State 3 moves to state 4 at the clock edge after the detector power becomes strictly greater than `thr_on_i`. `cxl_en_o` is 1 exactly in state 4.
- R7: State 4 moves to state 3 at the next edge when `cxl_pwr_i` is strictly less than `thr_off_i`. `cxl_pwr_i` has no effect in any other state.
- R8: In state 3, valid samples are counted. When the count reaches a non-zero `recal_ivl_i`, the state becomes 5. State 5 averages a new window as in R3 while the old offset stays applied. At the end of the window the new offset replaces the old one and the state returns to 3. The count restarts on each entry to state 3. A value of 0 disables recalibration, and state 4 never leads to state 5.
- R9: With the request low at a clock edge, the state becomes 0, all enables and `ref_valid_o` go low and the stored offset is cleared. The first samples after a later request are therefore forwarded without correction.
- R10: N is `cal_log2_i` clamped to the range 4 to 10: values below 4 act as 4 and values above 10 act as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request to run the cancellation path |
| smp_valid_i | input | 1 | Reference sample strobe |
| smp_i_i | input | W | Reference sample, in-phase, signed |
| smp_q_i | input | W | Reference sample, quadrature, signed |
| cal_log2_i | input | 4 | log2 of the calibration window length |
| det_shift_i | input | SW | Leak shift of the power detector |
| thr_on_i | input | PW | Enable threshold for the detector power |
| thr_off_i | input | PW | Disable threshold for the canceller power |
| recal_ivl_i | input | CW | Samples between recalibrations (0 = never) |
| cxl_pwr_i | input | PW | Summed output power estimate from the canceller |
| state_o | output | 3 | Current state code |
| fe_en_o | output | 1 | Reference front-end power enable |
| cxl_en_o | output | 1 | Canceller enable |
| ref_valid_o | output | 1 | Corrected sample strobe |
| ref_i_o | output | W+1 | Offset-corrected sample, in-phase |
| ref_q_o | output | W+1 | Offset-corrected sample, quadrature |

## Verification
The assertions check these rules on every cycle:
- a dropped request forces the idle state and a cleared offset;
- the canceller only starts after a detector reading above the enable threshold;
- a low canceller power always ends cancelling;
- recalibration is only ever entered from detection;
- the stored offset never moves during detection or cancelling;
- the detector holds zero whenever it is disabled.

Only the bench scenarios can show the rest:
- the exact length of the warm-up and of the window for each clamped N;
- the rounding of negative averages;
- the boundary behaviour of both strict threshold comparisons;
- the leaky integrator's step response;
- the values forwarded while an old offset is still applied.

// File: rtl/xcan_pkg.sv
`timescale 1ns/1ps
package xcan_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_FEON  = 3'd1,
        ST_CAL   = 3'd2,
        ST_DET   = 3'd3,
        ST_CXL   = 3'd4,
        ST_RECAL = 3'd5
    } xst_e;
endpackage

// File: rtl/xcan_avg.sv
`timescale 1ns/1ps
module xcan_avg #(
    parameter int W    = 12,
    parameter int NMIN = 4,
    parameter int NMAX = 10,
    localparam int LW  = $clog2(NMAX + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                clr_i,
    input  logic                add_i,
    input  logic signed [W-1:0] smp_i_i,
    input  logic signed [W-1:0] smp_q_i,
    input  logic [LW-1:0]       log2_i,
    output logic                done_o,
    output logic signed [W-1:0] avg_i_o,
    output logic signed [W-1:0] avg_q_o
);
    localparam int AW = W + NMAX + 1;
    localparam int KW = NMAX + 1;

    typedef struct packed {
        logic signed [AW-1:0] ai;
        logic signed [AW-1:0] aq;
        logic [KW-1:0]        cnt;
    } avg_s;

    avg_s r_d, r_q;
    logic [LW-1:0] n_eff;
    logic [KW-1:0] last;
    logic signed [AW-1:0] sum_i, sum_q;

    always_comb begin
        // window length is clamped to the supported range (R10)
        if (log2_i < LW'(NMIN))      n_eff = LW'(NMIN);
        else if (log2_i > LW'(NMAX)) n_eff = LW'(NMAX);
        else                         n_eff = log2_i;
        last    = (KW'(1) << n_eff) - KW'(1);
        sum_i   = r_q.ai + AW'(smp_i_i);
        sum_q   = r_q.aq + AW'(smp_q_i);
        done_o  = add_i && (r_q.cnt == last);
        avg_i_o = W'(sum_i >>> n_eff);
        avg_q_o = W'(sum_q >>> n_eff);
        r_d = r_q;
        if (clr_i || done_o) begin
            r_d = '0;
        end else if (add_i) begin
            r_d.ai  = sum_i;
            r_d.aq  = sum_q;
            r_d.cnt = r_q.cnt + KW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    // R3: a cleared averager restarts its window from zero
    a_r3_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (r_q.cnt == '0) && (r_q.ai == '0) && (r_q.aq == '0));
endmodule

// File: rtl/xcan_pdet.sv
`timescale 1ns/1ps
module xcan_pdet #(
    parameter int W1 = 13,
    parameter int PW = 27,
    parameter int SW = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 vld_i,
    input  logic signed [W1-1:0] x_i_i,
    input  logic signed [W1-1:0] x_q_i,
    input  logic [SW-1:0]        shift_i,
    output logic [PW-1:0]        pwr_o
);
    logic signed [PW-1:0] xi_w, xq_w;
    logic [PW-1:0] e_w, p_d, p_q;

    assign xi_w = PW'(x_i_i);
    assign xq_w = PW'(x_q_i);

    always_comb begin
        e_w = $unsigned(xi_w * xi_w) + $unsigned(xq_w * xq_w);
        p_d = p_q;
        if (!en_i)      p_d = '0;
        else if (vld_i) p_d = p_q - (p_q >> shift_i) + (e_w >> shift_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    assign pwr_o = p_q;

    // R5: a disabled detector reads zero at the next edge
    a_r5_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (pwr_o == '0));
endmodule

// File: rtl/xcan_path_seq.sv
`timescale 1ns/1ps
module xcan_path_seq
    import xcan_pkg::*;
#(
    parameter int W        = 12,
    parameter int NMIN     = 4,
    parameter int NMAX     = 10,
    parameter int WARM_CYC = 4,
    parameter int CW       = 16,
    parameter int SW       = 5,
    localparam int LW      = $clog2(NMAX + 1),
    localparam int PW      = 2 * (W + 1) + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_i,
    input  logic                smp_valid_i,
    input  logic signed [W-1:0] smp_i_i,
    input  logic signed [W-1:0] smp_q_i,
    input  logic [LW-1:0]       cal_log2_i,
    input  logic [SW-1:0]       det_shift_i,
    input  logic [PW-1:0]       thr_on_i,
    input  logic [PW-1:0]       thr_off_i,
    input  logic [CW-1:0]       recal_ivl_i,
    input  logic [PW-1:0]       cxl_pwr_i,
    output logic [2:0]          state_o,
    output logic                fe_en_o,
    output logic                cxl_en_o,
    output logic                ref_valid_o,
    output logic signed [W:0]   ref_i_o,
    output logic signed [W:0]   ref_q_o
);
    typedef struct packed {
        xst_e                st;
        logic [CW-1:0]       cnt;
        logic signed [W-1:0] off_i;
        logic signed [W-1:0] off_q;
        logic                ref_v;
        logic signed [W:0]   ref_i;
        logic signed [W:0]   ref_q;
    } seq_s;

    seq_s s_d, s_q;

    logic cal_on, avg_add, avg_clr, avg_done, det_en;
    logic signed [W-1:0] avg_i, avg_q;
    logic signed [W:0] cor_i, cor_q;
    logic [PW-1:0] det_pwr;

    assign cal_on  = (s_q.st == ST_CAL) || (s_q.st == ST_RECAL);
    assign avg_add = cal_on && smp_valid_i;
    assign avg_clr = !cal_on || !req_i;
    assign det_en  = (s_q.st == ST_DET) && req_i;
    assign cor_i   = (W+1)'(smp_i_i) - (W+1)'(s_q.off_i);
    assign cor_q   = (W+1)'(smp_q_i) - (W+1)'(s_q.off_q);

    xcan_avg #(.W(W), .NMIN(NMIN), .NMAX(NMAX)) u_avg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (avg_clr),
        .add_i   (avg_add),
        .smp_i_i (smp_i_i),
        .smp_q_i (smp_q_i),
        .log2_i  (cal_log2_i),
        .done_o  (avg_done),
        .avg_i_o (avg_i),
        .avg_q_o (avg_q)
    );

    xcan_pdet #(.W1(W + 1), .PW(PW), .SW(SW)) u_pdet (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (det_en),
        .vld_i   (smp_valid_i),
        .x_i_i   (cor_i),
        .x_q_i   (cor_q),
        .shift_i (det_shift_i),
        .pwr_o   (det_pwr)
    );

    always_comb begin
        s_d = s_q;
        s_d.ref_v = (s_q.st != ST_OFF) && smp_valid_i;
        if (s_d.ref_v) begin
            s_d.ref_i = cor_i;
            s_d.ref_q = cor_q;
        end
        unique case (s_q.st)
            ST_OFF: begin
                s_d.st  = ST_FEON;
                s_d.cnt = '0;
            end
            ST_FEON: begin
                if (s_q.cnt == CW'(WARM_CYC - 1)) begin
                    s_d.st  = ST_CAL;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            ST_CAL, ST_RECAL: begin
                if (avg_done) begin
                    s_d.off_i = avg_i;
                    s_d.off_q = avg_q;
                    s_d.st    = ST_DET;
                    s_d.cnt   = '0;
                end
            end
            ST_DET: begin
                if (det_pwr > thr_on_i) begin
                    s_d.st  = ST_CXL;
                    s_d.cnt = '0;
                end else if ((recal_ivl_i != '0) && smp_valid_i) begin
                    if (s_q.cnt >= recal_ivl_i - CW'(1)) begin
                        s_d.st  = ST_RECAL;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
            end
            ST_CXL: begin
                if (cxl_pwr_i < thr_off_i) begin
                    s_d.st  = ST_DET;
                    s_d.cnt = '0;
                end
            end
            default: s_d = '0;
        endcase
        if (!req_i) s_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign state_o     = s_q.st;
    assign fe_en_o     = (s_q.st != ST_OFF);
    assign cxl_en_o    = (s_q.st == ST_CXL);
    assign ref_valid_o = s_q.ref_v;
    assign ref_i_o     = s_q.ref_i;
    assign ref_q_o     = s_q.ref_q;

    // R2: a request in idle starts the front end at the next edge
    a_r2_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_OFF) && req_i |=> (s_q.st == ST_FEON) && fe_en_o);

    // R4: the offset stays fixed while detecting or cancelling
    a_r4_offset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.st == ST_DET) || (s_q.st == ST_CXL)) && req_i |=> $stable(s_q.off_i) && $stable(s_q.off_q));

    // R6: the canceller starts only after a detector reading above the enable threshold
    a_r6_cancel_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cxl_en_o) |-> $past(s_q.st == ST_DET) && $past(det_pwr > thr_on_i));

    // R7: low canceller power always ends cancelling
    a_r7_cancel_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_CXL) && req_i && (cxl_pwr_i < thr_off_i) |=> (s_q.st == ST_DET));

    // R8: recalibration is only entered from detection
    a_r8_recal_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_RECAL) && ($past(s_q.st) != ST_RECAL) |-> ($past(s_q.st) == ST_DET));

    // R9: a dropped request clears state, enables and offset
    a_r9_drop_to_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> (s_q.st == ST_OFF) && !cxl_en_o && !ref_valid_o && (s_q.off_i == '0) && (s_q.off_q == '0));
endmodule

// File: tb/sim_xcan_path_seq.sv
`timescale 1ns/1ps
module sim_xcan_path_seq;
    localparam int W    = 12;
    localparam int WARM = 4;
    localparam int CW   = 16;
    localparam int SW   = 5;
    localparam int PW   = 2 * (W + 1) + 1;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, vld = 1'b0;
    logic signed [W-1:0] si = '0, sq = '0;
    logic [3:0] lg = 4'd4;
    logic [SW-1:0] sh = '0;
    logic [PW-1:0] thr_on = '1, thr_off = '0, cxp = '0;
    logic [CW-1:0] ivl = '0;
    logic [2:0] st;
    logic fe, cx, rv;
    logic signed [W:0] ri, rq;

    int n_chk = 0, n_bad = 0;
    int oi, oq;

    always #2.5 clk = ~clk;

    xcan_path_seq #(.W(W), .WARM_CYC(WARM), .CW(CW), .SW(SW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .smp_valid_i(vld),
        .smp_i_i(si), .smp_q_i(sq), .cal_log2_i(lg), .det_shift_i(sh),
        .thr_on_i(thr_on), .thr_off_i(thr_off), .recal_ivl_i(ivl),
        .cxl_pwr_i(cxp), .state_o(st), .fe_en_o(fe), .cxl_en_o(cx),
        .ref_valid_o(rv), .ref_i_o(ri), .ref_q_o(rq)
    );

    // rows: cal_log2 input, expected clamped N, I level, Q level, gaps on
    localparam int NROW = 4;
    localparam int TBL [NROW][5] = '{
        '{2,  4, -37,   50,   0},
        '{12, 10, 100,  -1,   1},
        '{5,  5,  -1,    0,   1},
        '{4,  4,  2046, -2047, 0}
    };

    task automatic chk(input string rq_tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq_tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic putraw(input int a, input int b);
        si = W'(a); sq = W'(b); vld = 1'b1;
        tick();
        vld = 1'b0;
    endtask

    task automatic put(input int x, input int y);
        putraw(x + oi, y + oq);
    endtask

    task automatic bring_up(input int lg_in, input int nexp, input int di, input int dq,
                            input int gaps, output int o_i, output int o_q);
        longint sum_i, sum_q;
        int k, g, w;
        bit first;
        req = 1'b0; vld = 1'b0;
        tick(); tick();
        chk("R9 idle after request drop", st, 0);
        lg = lg_in[3:0]; req = 1'b1;
        tick();
        chk("R2 warm-up state", st, 1);
        chk("R2 front end enable", fe, 1);
        w = 0;
        while (st == 3'd1 && w < 1000) begin w++; tick(); end
        chk("R2 warm-up length", w, WARM);
        chk("R2 calibration entered", st, 2);
        sum_i = 0; sum_q = 0; k = 0; g = 0; first = 1'b1;
        while (k < (1 << nexp)) begin
            if (gaps != 0 && g % 4 == 3) begin
                vld = 1'b0;
            end else begin
                vld = 1'b1;
                si = W'(di + (k % 3) - 1);
                sq = W'(dq - (k % 3) + 1);
                sum_i += si; sum_q += sq; k++;
            end
            g++;
            tick();
            if (vld && first) begin
                first = 1'b0;
                chk("R9 offset cleared, first output raw I", ri, si);
                chk("R4 valid strobe", rv, 1);
            end
            if (vld && k == (1 << nexp) - 1) chk("R3/R10 one sample short stays in CAL", st, 2);
        end
        vld = 1'b0;
        chk("R3/R10 window of 2^N valid samples ends CAL", st, 3);
        o_i = int'(sum_i >>> nexp);
        o_q = int'(sum_q >>> nexp);
        putraw(0, 0);
        chk("R4 offset subtracted I", ri, -o_i);
        chk("R4 offset subtracted Q", rq, -o_q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        // R1 reset state
        tick(); tick();
        chk("R1 state in reset", st, 0);
        chk("R1 fe_en in reset", fe, 0);
        chk("R1 cxl_en in reset", cx, 0);
        chk("R1 ref_valid in reset", rv, 0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R1 idle with request low", st, 0);

        // table of calibration windows (R3, R4, R10)
        for (int r = 0; r < NROW; r++) begin
            bring_up(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], oi, oq);
        end

        // detection and cancel thresholds (R5, R6, R7)
        bring_up(4, 4, 0, 0, 0, oi, oq);
        sh = '0; thr_on = PW'(100); thr_off = PW'(20); cxp = '0; ivl = '0;
        tick(); tick();
        chk("R7 canceller power ignored outside CANCEL", st, 3);
        put(10, 0); tick();
        chk("R6 power equal to threshold does not enable", st, 3);
        put(10, 1);
        chk("R6 one edge before enable", st, 3);
        tick();
        chk("R6 cancel state", st, 4);
        chk("R6 cxl_en high", cx, 1);
        cxp = PW'(20); tick(); tick();
        chk("R7 power equal to off threshold keeps cancelling", st, 4);
        cxp = PW'(19); tick();
        chk("R7 exit to DETECT", st, 3);
        chk("R7 cxl_en low", cx, 0);
        thr_on = PW'(50); cxp = '0;
        tick(); tick(); tick();
        chk("R5 detector cleared after cancel", st, 3);

        // leaky integrator step response (R5)
        sh = SW'(2); thr_on = PW'(9); p = 0;
        for (int j = 0; j < 3; j++) begin
            put(4, 0);
            chk("R5 leaky power not yet compared", st, 3);
            p = p - (p >> 2) + (16 >> 2);
        end
        tick();
        chk("R5 leaky power crosses threshold", st, (p > 9) ? 4 : 3);
        req = 1'b0; tick();
        chk("R9 idle one edge after drop", st, 0);
        chk("R9 fe_en low", fe, 0);
        chk("R9 cxl_en low", cx, 0);

        // periodic recalibration (R8)
        sh = '0; thr_on = '1;
        bring_up(3, 4, 7, -3, 0, oi, oq);
        ivl = CW'(5);
        for (int j = 0; j < 4; j++) begin
            putraw(300, -200);
            chk("R8 counting in DETECT", st, 3);
        end
        putraw(300, -200);
        chk("R8 recalibration entered", st, 5);
        for (int j = 0; j < 16; j++) begin
            putraw(300, -200);
            if (j == 0) chk("R8 old offset still applied", ri, 300 - oi);
            if (j < 15) chk("R8 recalibrating", st, 5);
        end
        chk("R8 back to DETECT", st, 3);
        putraw(300, -200);
        chk("R8 new offset I", ri, 0);
        chk("R8 new offset Q", rq, 0);
        ivl = '0;
        for (int j = 0; j < 20; j++) putraw(300, -200);
        chk("R8 zero interval disables recalibration", st, 3);

        // no recalibration while cancelling (R8), then drop (R9)
        ivl = CW'(3); thr_on = '0; cxp = '1; thr_off = PW'(1);
        putraw(301, -200); tick();
        chk("R6 cancel on small power", st, 4);
        for (int j = 0; j < 10; j++) putraw(301, -200);
        chk("R8 no recalibration from CANCEL", st, 4);
        req = 1'b0; tick();
        chk("R9 idle after drop from CANCEL", st, 0);
        chk("R9 cxl_en low", cx, 0);
        chk("R9 ref_valid low", rv, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule